// File: doc/BRIEF.md
# SPI FIFO Interrupt Status Unit

This block is the interrupt register set of a serial peripheral controller whose transmit and receive paths each buffer up to a parameterised number of byte entries (32 by default). The FIFOs themselves live elsewhere. This unit receives each FIFO's occupancy count and full flag, plus single-cycle pulses for three error events. It keeps a seven-bit status word, an interrupt mask and two programmable thresholds, and it drives one level-sensitive interrupt request.

Three status bits are sticky. An event pulse sets the bit, and only a write-one-to-clear to the status word clears it. The other four status bits are recomputed continuously from the FIFO inputs and the thresholds, so they always show the present FIFO state. The mask cannot be written directly. Software sets mask bits by writing ones to a mask-set register and clears them by writing ones to a mask-clear register.

All registers sit behind a word-wide port with a 3-bit word address. Reads are combinational and have no side effects. The word addresses are: 0 status, 1 mask-set, 2 mask-clear, 3 mask, 4 transmit threshold, 5 receive threshold. Any other address reads as zero and ignores writes.

Top module: `spi_irq_unit`

## Requirements
- R1: The status word uses these bit positions: bit 6 transmit underflow, bit 5 receive full, bit 4 receive threshold reached, bit 3 transmit full, bit 2 transmit below threshold, bit 1 mode fail, bit 0 receive overflow.
- R2: Status bits 6, 1 and 0 are set on the clock edge where their event pulse is high, and they stay set on every later cycle until cleared.
- R3: A write to the status address clears exactly those sticky bits written as 1. Bits written as 0 keep their value. Bits 5, 4, 3 and 2 are unaffected by any status write.
- R4: Status bit 4 reads 1 exactly when the receive count is greater than or equal to the receive threshold. Status bit 5 follows the receive full flag.
- R5: Status bit 2 reads 1 exactly when the transmit count is strictly below the transmit threshold. Status bit 3 follows the transmit full flag.
- R6: Writing 1s to the mask-set address sets those mask bits. Writing 1s to the mask-clear address clears them. Writes to the mask address have no effect.
- R7: The mask-set and mask-clear addresses read as zero. Status and mask reads return zero in bits 31 to 7.
- R8: The interrupt output is registered. After each clock edge it equals the OR over all bits of (mask AND status) as those values stood just before that edge.
- R9: After reset both thresholds are 1, the mask is 0 and the sticky bits are 0. With empty FIFOs the status word therefore reads 0x04 and the interrupt is low.
- R10: If an event pulse and a write-one-to-clear for the same sticky bit occur in the same cycle, the bit ends up set.
- R11: A threshold write keeps only the low count-width bits of the data, and a threshold read returns that value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_count | input | $clog2(FIFO_DEPTH+1) | Transmit FIFO occupancy |
| rx_count | input | $clog2(FIFO_DEPTH+1) | Receive FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_full | input | 1 | Receive FIFO full flag |
| ev_tx_underflow | input | 1 | Transmit underflow event pulse |
| ev_mode_fail | input | 1 | Mode-fail event pulse |
| ev_rx_overflow | input | 1 | Receive overflow event pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with FIFO_DEPTH set to 8. This makes the count and threshold fields 4 bits wide. With that setting, every threshold value from 0 to 15 can be combined with every occupancy from 0 to 8 on both FIFOs, which covers both sides of each comparison and thresholds above the FIFO depth. The small width also makes the truncation of wide threshold writes visible. The three sticky bits are each driven through set, partial clear, full clear and the event-against-clear collision. The interrupt is timed against mask changes, sticky events and clears.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int ST_W = 7;
    localparam int NSTICKY = 3;

    // Status bit positions
    localparam int B_TXUF   = 6;
    localparam int B_RXFULL = 5;
    localparam int B_RXTHR  = 4;
    localparam int B_TXFULL = 3;
    localparam int B_TXTHR  = 2;
    localparam int B_MODEF  = 1;
    localparam int B_RXOVF  = 0;

    typedef enum logic [2:0] {
        A_STATUS   = 3'd0,
        A_MASK_SET = 3'd1,
        A_MASK_CLR = 3'd2,
        A_MASK     = 3'd3,
        A_TX_THR   = 3'd4,
        A_RX_THR   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic tx_underflow;
        logic mode_fail;
        logic rx_overflow;
    } sticky_t;

    typedef struct packed {
        logic rx_full;
        logic rx_at_thr;
        logic tx_full;
        logic tx_below_thr;
    } live_t;

    function automatic logic [ST_W-1:0] pack_status(sticky_t s, live_t l);
        logic [ST_W-1:0] w;
        w = '0;
        w[B_TXUF]   = s.tx_underflow;
        w[B_RXFULL] = l.rx_full;
        w[B_RXTHR]  = l.rx_at_thr;
        w[B_TXFULL] = l.tx_full;
        w[B_TXTHR]  = l.tx_below_thr;
        w[B_MODEF]  = s.mode_fail;
        w[B_RXOVF]  = s.rx_overflow;
        return w;
    endfunction

    function automatic sticky_t sticky_sel(logic [ST_W-1:0] w);
        sticky_t s;
        s.tx_underflow = w[B_TXUF];
        s.mode_fail    = w[B_MODEF];
        s.rx_overflow  = w[B_RXOVF];
        return s;
    endfunction

endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic q;

            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (ev_i[i])
                    q <= 1'b1;
                else if (clr_i[i])
                    q <= 1'b0;
            end

            assign q_o[i] = q;

            // R10: the event takes priority over a same-cycle clear
            assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
                (ev_i[i] && clr_i[i]) |=> q_o[i]);

            // R2: once set, the bit holds unless a clear arrives
            assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
                (q_o[i] && !clr_i[i]) |=> q_o[i]);

            // R2: the bit never rises without an event
            assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
                (!q_o[i] && !ev_i[i]) |=> !q_o[i]);
        end
    endgenerate

endmodule

// File: rtl/spi_irq_live.sv
module spi_irq_live
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic [CNT_W-1:0] rx_thr,
    input  logic             tx_full,
    input  logic             rx_full,
    output live_t            live_o
);

    always_comb begin
        live_o.rx_full      = rx_full;
        live_o.rx_at_thr    = (rx_count >= rx_thr);
        live_o.tx_full      = tx_full;
        live_o.tx_below_thr = (tx_count < tx_thr);
    end

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    input  logic [ST_W-1:0]  status,
    output logic [ST_W-1:0]  mask_o,
    output logic [CNT_W-1:0] tx_thr_o,
    output logic [CNT_W-1:0] rx_thr_o,
    output sticky_t          clr_o,
    output logic [31:0]      rdata_o
);

    logic [ST_W-1:0]  mask_q;
    logic [CNT_W-1:0] tx_thr_q;
    logic [CNT_W-1:0] rx_thr_q;
    logic             unused_hi;

    assign unused_hi = ^wdata[31:ST_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            tx_thr_q <= CNT_W'(1);
            rx_thr_q <= CNT_W'(1);
        end else if (wr) begin
            case (addr)
                A_MASK_SET: mask_q   <= mask_q | wdata[ST_W-1:0];
                A_MASK_CLR: mask_q   <= mask_q & ~wdata[ST_W-1:0];
                A_TX_THR:   tx_thr_q <= wdata[CNT_W-1:0];
                A_RX_THR:   rx_thr_q <= wdata[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        if (wr && addr == A_STATUS)
            clr_o = sticky_sel(wdata[ST_W-1:0]);
        else
            clr_o = '0;
    end

    always_comb begin
        rdata_o = '0;
        case (addr)
            A_STATUS: rdata_o[ST_W-1:0]  = status;
            A_MASK:   rdata_o[ST_W-1:0]  = mask_q;
            A_TX_THR: rdata_o[CNT_W-1:0] = tx_thr_q;
            A_RX_THR: rdata_o[CNT_W-1:0] = rx_thr_q;
            default:  rdata_o = '0;
        endcase
    end

    assign mask_o   = mask_q;
    assign tx_thr_o = tx_thr_q;
    assign rx_thr_o = rx_thr_q;

    assert_mask_set_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_MASK_SET) |=> ((mask_q & $past(wdata[ST_W-1:0])) == $past(wdata[ST_W-1:0])));

    assert_mask_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_MASK_CLR) |=> ((mask_q & $past(wdata[ST_W-1:0])) == '0));

    assert_mask_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_MASK) |=> $stable(mask_q));

    assert_reset_values_R9: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && tx_thr_q == CNT_W'(1) && rx_thr_q == CNT_W'(1)));

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             tx_full,
    input  logic             rx_full,
    input  logic             ev_tx_underflow,
    input  logic             ev_mode_fail,
    input  logic             ev_rx_overflow,
    output logic             irq
);

    sticky_t          ev_vec;
    sticky_t          clr_vec;
    sticky_t          st_q;
    live_t            live;
    logic [ST_W-1:0]  status;
    logic [ST_W-1:0]  mask;
    logic [CNT_W-1:0] tx_thr;
    logic [CNT_W-1:0] rx_thr;
    logic [NSTICKY-1:0] st_bits;

    assign ev_vec.tx_underflow = ev_tx_underflow;
    assign ev_vec.mode_fail    = ev_mode_fail;
    assign ev_vec.rx_overflow  = ev_rx_overflow;

    spi_irq_sticky #(.N(NSTICKY)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .ev_i  (ev_vec),
        .clr_i (clr_vec),
        .q_o   (st_bits)
    );

    assign st_q = sticky_t'(st_bits);

    spi_irq_live #(.CNT_W(CNT_W)) u_live (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .tx_full  (tx_full),
        .rx_full  (rx_full),
        .live_o   (live)
    );

    assign status = pack_status(st_q, live);

    spi_irq_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .status   (status),
        .mask_o   (mask),
        .tx_thr_o (tx_thr),
        .rx_thr_o (rx_thr),
        .clr_o    (clr_vec),
        .rdata_o  (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= |(mask & status);
    end

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (|(mask & status)) |=> irq);

    assert_irq_fall_R8: assert property (@(posedge clk) disable iff (rst)
        !(|(mask & status)) |=> !irq);

    assert_rdata_width_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_STATUS || reg_addr == A_MASK) |-> (reg_rdata[31:ST_W] == '0));

    assert_rdata_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_MASK_SET || reg_addr == A_MASK_CLR) |-> (reg_rdata == '0));

endmodule

// File: tb/spi_irq_unit_tb.sv
module spi_irq_unit_tb;

    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [CW-1:0] tx_count = '0;
    logic [CW-1:0] rx_count = '0;
    logic          tx_full = 1'b0;
    logic          rx_full = 1'b0;
    logic          ev_tx_underflow = 1'b0;
    logic          ev_mode_fail = 1'b0;
    logic          ev_rx_overflow = 1'b0;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model
    logic [2:0]  m_st;     // {underflow, modefail, overflow}
    logic [6:0]  m_mask;
    logic [CW-1:0] m_txthr;
    logic [CW-1:0] m_rxthr;

    always #5 clk = ~clk;

    spi_irq_unit #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .tx_count (tx_count), .rx_count (rx_count),
        .tx_full (tx_full), .rx_full (rx_full),
        .ev_tx_underflow (ev_tx_underflow), .ev_mode_fail (ev_mode_fail),
        .ev_rx_overflow (ev_rx_overflow), .irq (irq)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] w;
        w = '0;
        w[6] = m_st[2];
        w[5] = rx_full;
        w[4] = (rx_count >= m_rxthr);
        w[3] = tx_full;
        w[2] = (tx_count < m_txthr);
        w[1] = m_st[1];
        w[0] = m_st[0];
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        if (idx == 2) ev_tx_underflow = 1'b1;
        if (idx == 1) ev_mode_fail = 1'b1;
        if (idx == 0) ev_rx_overflow = 1'b1;
        @(negedge clk);
        ev_tx_underflow = 1'b0; ev_mode_fail = 1'b0; ev_rx_overflow = 1'b0;
    endtask

    function automatic int sbit(input int idx);
        return (idx == 2) ? 6 : idx;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        m_st = '0; m_mask = '0; m_txthr = CW'(1); m_rxthr = CW'(1);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(3'd0, v); chk("R9 status after reset", v, 32'h04);
        rd(3'd3, v); chk("R9 mask after reset", v, 32'h0);
        rd(3'd4, v); chk("R9 tx threshold", v, 32'h1);
        rd(3'd5, v); chk("R9 rx threshold", v, 32'h1);
        chk("R9 irq after reset", {31'b0, irq}, 32'h0);

        // R6 / R7 / R8 mask handling
        wr(3'd1, 32'hFFFF_FFFF); m_mask = 7'h7F;
        chk("R8 irq latency one edge", {31'b0, irq}, 32'h0);
        rd(3'd1, v); chk("R7 mask-set reads zero", v, 32'h0);
        rd(3'd2, v); chk("R7 mask-clear reads zero", v, 32'h0);
        rd(3'd3, v); chk("R6 R7 mask after set", v, 32'h7F);
        @(negedge clk);
        chk("R8 irq from tx below threshold", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h7B); m_mask = 7'h04;
        rd(3'd3, v); chk("R6 mask after clear", v, {25'b0, m_mask});
        wr(3'd3, 32'hFF); 
        rd(3'd3, v); chk("R6 mask write ignored", v, {25'b0, m_mask});
        wr(3'd2, 32'h04); m_mask = 7'h00;
        rd(3'd3, v); chk("R6 mask cleared", v, 32'h0);
        @(negedge clk);
        chk("R8 irq low with mask zero", {31'b0, irq}, 32'h0);

        // R1 R2 R3 R10 sticky bits
        for (int i = 0; i < 3; i++) begin
            pulse(i); m_st[i] = 1'b1;
            rd(3'd0, v); chk("R1 R2 sticky set by event", v, exp_status());
            repeat (3) @(negedge clk);
            rd(3'd0, v); chk("R2 sticky bit holds", v, exp_status());
            wr(3'd0, 32'h7F & ~(32'h1 << sbit(i)));
            for (int j = 0; j < 3; j++) if (j != i) m_st[j] = 1'b0;
            rd(3'd0, v); chk("R3 partial clear keeps bit", v, exp_status());
            wr(3'd0, 32'h1 << sbit(i)); m_st[i] = 1'b0;
            rd(3'd0, v); chk("R3 clear by writing one", v, exp_status());
            // R10 collision
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1 << sbit(i);
            if (i == 2) ev_tx_underflow = 1'b1;
            if (i == 1) ev_mode_fail = 1'b1;
            if (i == 0) ev_rx_overflow = 1'b1;
            @(negedge clk);
            reg_wr = 1'b0; reg_wdata = '0;
            ev_tx_underflow = 1'b0; ev_mode_fail = 1'b0; ev_rx_overflow = 1'b0;
            m_st[i] = 1'b1;
            rd(3'd0, v); chk("R10 event beats clear", v, exp_status());
            wr(3'd0, 32'h1 << sbit(i)); m_st[i] = 1'b0;
        end

        // R3 live bits untouched by status write
        rx_full = 1'b1; tx_full = 1'b1;
        wr(3'd0, 32'h7F);
        rd(3'd0, v); chk("R3 live bits survive write", v, exp_status());
        rx_full = 1'b0; tx_full = 1'b0;
        rd(3'd0, v); chk("R4 R5 full flags follow", v, exp_status());

        // R11 truncation of threshold writes
        wr(3'd4, 32'h0000_01F5); m_txthr = CW'(5);
        rd(3'd4, v); chk("R11 tx threshold truncated", v, 32'h5);
        wr(3'd5, 32'hFFFF_FFF3); m_rxthr = CW'(3);
        rd(3'd5, v); chk("R11 rx threshold truncated", v, 32'h3);

        // R4 R5 R11 exhaustive threshold/count sweep
        for (int t = 0; t < (1 << CW); t++) begin
            wr(3'd4, t); m_txthr = CW'(t);
            wr(3'd5, (1 << CW) - 1 - t); m_rxthr = CW'((1 << CW) - 1 - t);
            rd(3'd4, v); chk("R11 tx threshold readback", v, t);
            rd(3'd5, v); chk("R11 rx threshold readback", v, (1 << CW) - 1 - t);
            for (int c = 0; c <= DEPTH; c++) begin
                @(negedge clk);
                tx_count = CW'(c);
                rx_count = CW'(DEPTH - c);
                rd(3'd0, v); chk("R4 R5 threshold compare", v, exp_status());
            end
        end
        tx_count = '0; rx_count = '0;
        wr(3'd4, 1); m_txthr = CW'(1);
        wr(3'd5, 1); m_rxthr = CW'(1);

        // R8 timing with a sticky source
        wr(3'd1, 32'h01); m_mask = 7'h01;
        pulse(0); m_st[0] = 1'b1;
        chk("R8 irq not yet after event", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq one edge after event", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h01); m_st[0] = 1'b0;
        chk("R8 irq still high at clear edge", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R8 irq low after clear", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule